// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two parallel bidirectional buses, here called side A and side B. Each direction of transfer owns a holding register. The A-to-B register samples side A when its capture strobe rises. The B-to-A register samples side B when its own capture strobe rises. The two strobes arrive from outside the clock domain. Each one is synchronised into the system clock and edge-detected, so that every rising edge loads its register exactly once.

An active-low drive enable and a direction input choose which side, if either, is driven. For the side being driven, a per-direction source pick chooses between two values: the live value on the opposite side, or the value held in that direction's register. Capture keeps working whether the outputs are enabled, pointed the other way, or isolated. The block can therefore stage data on both sides while it drives neither.

Each bidirectional bus is modelled as three separate vectors: an input, an output and a per-bit drive enable. A pad ring or a tri-state wrapper combines them outside the block.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Each rising edge of `cap_ab` loads `a_in` into the A-to-B register exactly once, within a few system clocks.
- R2: Each rising edge of `cap_ba` loads `b_in` into the B-to-A register exactly once, within a few system clocks.
- R3: Capture does not depend on `drive_en_n` or `toward_b`. Both registers can load in the same window, including while both sides are isolated.
- R4: With `drive_en_n` = 1, `a_drv` and `b_drv` are all zero, and `a_out` and `b_out` are zero.
- R5: With `drive_en_n` = 0 and `toward_b` = 0, every bit of `a_drv` is 1 and `b_drv` is zero. With `drive_en_n` = 0 and `toward_b` = 1, every bit of `b_drv` is 1 and `a_drv` is zero. An undriven output reads zero.
- R6: While side A is driven, `a_out` equals `b_in` when `pick_ba_reg` = 0 and equals the B-to-A register when `pick_ba_reg` = 1.
- R7: While side B is driven, `b_out` equals `a_in` when `pick_ab_reg` = 0 and equals the A-to-B register when `pick_ab_reg` = 1.
- R8: `a_drv` and `b_drv` are never non-zero in the same cycle.
- R9: The data path does not invert, and every bit position behaves alike for all 256 byte values.
- R10: A synchronous reset (`rst_n` = 0 at a clock edge) clears both registers to zero.
- R11: A register samples only its own side's input vector. The value the block is driving onto that side is never loaded in its place.
- R12: A strobe held high loads once. A change on the input while the strobe stays high is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drive_en_n | input | 1 | Output drive enable, active low |
| toward_b | input | 1 | 0 drives side A, 1 drives side B |
| pick_ab_reg | input | 1 | Source for side B: 0 live A, 1 stored A-to-B |
| pick_ba_reg | input | 1 | Source for side A: 0 live B, 1 stored B-to-A |
| cap_ab | input | 1 | Asynchronous capture strobe for the A-to-B register |
| cap_ba | input | 1 | Asynchronous capture strobe for the B-to-A register |
| a_in | input | W | Value seen on side A |
| a_out | output | W | Value driven onto side A |
| a_drv | output | W | Per-bit drive enable for side A |
| b_in | input | W | Value seen on side B |
| b_out | output | W | Value driven onto side B |
| b_drv | output | W | Per-bit drive enable for side B |

## Verification
The assertions check the following on every clock:
- the two sides are never driven together;
- isolation silences both sides;
- the drive decode matches the enable and direction inputs;
- the routed source matches the pick inputs;
- each internal load pulse lasts one cycle, stores the input seen in its own cycle, and leaves the register unchanged otherwise.

Only the bench scenarios can show the behaviour seen from the strobe pins, because the synchroniser latency hides it from single-cycle properties. This covers one load per strobe edge, no reload while a strobe stays high, capture during isolation or the opposite drive, and the reset clearing previously loaded data.

// File: rtl/bxr_pkg.sv
`timescale 1ns/1ps
package bxr_pkg;
  typedef enum logic [1:0] {DRV_NONE = 2'd0, DRV_SIDE_A = 2'd1, DRV_SIDE_B = 2'd2} drv_t;

  // Decode which side is driven from enable and direction.
  function automatic drv_t drive_target(input logic en_n, input logic to_b);
    if (en_n) return DRV_NONE;
    return to_b ? DRV_SIDE_B : DRV_SIDE_A;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
`timescale 1ns/1ps
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic [STAGES:0] shr;

  always_ff @(posedge clk) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[STAGES-1:0], strobe};
  end

  assign rise = shr[STAGES-1] & ~shr[STAGES];
endmodule

// File: rtl/hold_reg.sv
`timescale 1ns/1ps
module hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/side_drive.sv
`timescale 1ns/1ps
module side_drive #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         pick_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic [W-1:0] drv
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out[i] = en & (pick_stored ? stored[i] : live[i]);
    assign drv[i] = en;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
module bus_xcvr_reg #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drive_en_n,
  input  logic         toward_b,
  input  logic         pick_ab_reg,
  input  logic         pick_ba_reg,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv
);
  import bxr_pkg::*;

  logic         ld_ab, ld_ba;
  logic [W-1:0] q_ab, q_ba;
  drv_t         target;
  logic         en_a, en_b;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_ab (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .rise(ld_ab));
  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_ba (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .rise(ld_ba));

  hold_reg #(.W(W)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .load(ld_ab), .d(a_in), .q(q_ab));
  hold_reg #(.W(W)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .load(ld_ba), .d(b_in), .q(q_ba));

  assign target = drive_target(drive_en_n, toward_b);
  assign en_a   = (target == DRV_SIDE_A);
  assign en_b   = (target == DRV_SIDE_B);

  side_drive #(.W(W)) u_drv_a (
    .en(en_a), .pick_stored(pick_ba_reg), .live(b_in), .stored(q_ba),
    .out(a_out), .drv(a_drv));
  side_drive #(.W(W)) u_drv_b (
    .en(en_b), .pick_stored(pick_ab_reg), .live(a_in), .stored(q_ab),
    .out(b_out), .drv(b_drv));
endmodule

// File: rtl/bxr_checker.sv
`timescale 1ns/1ps
module bxr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         drive_en_n,
  input logic         toward_b,
  input logic         pick_ab_reg,
  input logic         pick_ba_reg,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] b_drv,
  input logic         ld_ab,
  input logic         ld_ba,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  AST_LOAD_AB: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ab |=> q_ab == $past(a_in)); // R1
  AST_LOAD_BA: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ba |=> q_ba == $past(b_in)); // R2
  AST_KEEP_AB: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ab |=> $stable(q_ab)); // R11
  AST_KEEP_BA: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ba |=> $stable(q_ba)); // R11
  AST_PULSE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ab |=> !ld_ab); // R12
  AST_PULSE_BA: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ba |=> !ld_ba); // R12
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_n |-> (a_drv == '0 && b_drv == '0 && a_out == '0 && b_out == '0)); // R4
  AST_DRIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en_n && !toward_b) |-> ((&a_drv) && b_drv == '0)); // R5
  AST_DRIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en_n && toward_b) |-> ((&b_drv) && a_drv == '0)); // R5
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_drv) && (|b_drv))); // R8
  AST_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (&a_drv) |-> (a_out == (pick_ba_reg ? q_ba : b_in))); // R6
  AST_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
    (&b_drv) |-> (b_out == (pick_ab_reg ? q_ab : a_in))); // R7
endmodule

bind bus_xcvr_reg bxr_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en_n(drive_en_n), .toward_b(toward_b),
  .pick_ab_reg(pick_ab_reg), .pick_ba_reg(pick_ba_reg),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_drv(a_drv), .b_drv(b_drv), .ld_ab(ld_ab), .ld_ba(ld_ba),
  .q_ab(q_ab), .q_ba(q_ba));

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/1ps
module bus_xcvr_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0, drive_en_n = 1'b1, toward_b = 1'b0;
  logic         pick_ab_reg = 1'b0, pick_ba_reg = 1'b0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;
  int n_chk = 0, n_fail = 0;

  bus_xcvr_reg #(.W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .drive_en_n(drive_en_n), .toward_b(toward_b),
    .pick_ab_reg(pick_ab_reg), .pick_ba_reg(pick_ba_reg),
    .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctrl(input logic en_n, input logic dir, input logic sab, input logic sba);
    @(negedge clk);
    drive_en_n = en_n; toward_b = dir; pick_ab_reg = sab; pick_ba_reg = sba;
    #2;
  endtask

  // Present values, raise the chosen strobes, hold, then drop them.
  task automatic capture(input logic do_ab, input logic do_ba,
                         input logic [W-1:0] va, input logic [W-1:0] vb);
    @(negedge clk); a_in = va; b_in = vb;
    @(negedge clk); cap_ab = do_ab; cap_ba = do_ba;
    repeat (6) @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Bring both stored values out through the normal drive path.
  task automatic read_stored(output logic [W-1:0] sab_v, output logic [W-1:0] sba_v);
    ctrl(1'b0, 1'b1, 1'b1, 1'b0); sab_v = b_out;
    ctrl(1'b0, 1'b0, 1'b0, 1'b1); sba_v = a_out;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] rab, rba;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    read_stored(rab, rba);
    chk("R10 reset ab", {24'd0, rab}, 32'h00);
    chk("R10 reset ba", {24'd0, rba}, 32'h00);

    // R10: loaded data cleared by a later reset
    capture(1'b1, 1'b1, 8'h77, 8'h88);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    read_stored(rab, rba);
    chk("R10 reload-clear ab", {24'd0, rab}, 32'h00);
    chk("R10 reload-clear ba", {24'd0, rba}, 32'h00);

    // R1, R2: single-direction captures leave the other register alone
    capture(1'b1, 1'b0, 8'h3C, 8'hFF);
    read_stored(rab, rba);
    chk("R1 capture ab", {24'd0, rab}, 32'h3C);
    chk("R2 untouched ba", {24'd0, rba}, 32'h00);
    capture(1'b0, 1'b1, 8'h00, 8'hA5);
    read_stored(rab, rba);
    chk("R2 capture ba", {24'd0, rba}, 32'hA5);
    chk("R1 untouched ab", {24'd0, rab}, 32'h3C);

    // R3, R4: simultaneous capture while isolated
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    capture(1'b1, 1'b1, 8'h96, 8'h69);
    chk("R4 isolated a_drv", {24'd0, a_drv}, 32'h00);
    chk("R4 isolated b_drv", {24'd0, b_drv}, 32'h00);
    chk("R4 isolated outs", {16'd0, a_out, b_out}, 32'h0000);
    read_stored(rab, rba);
    chk("R3 isolated ab", {24'd0, rab}, 32'h96);
    chk("R3 isolated ba", {24'd0, rba}, 32'h69);

    // R11: side A driven with live B while A register captures a_in
    ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    capture(1'b1, 1'b0, 8'h0F, 8'hF0);
    chk("R11 a driven value", {24'd0, a_out}, 32'hF0);
    ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    capture(1'b0, 1'b1, 8'h5A, 8'hC3);
    chk("R11 b driven value", {24'd0, b_out}, 32'h5A);
    read_stored(rab, rba);
    chk("R11 ab from a_in", {24'd0, rab}, 32'h0F);
    chk("R11 ba from b_in", {24'd0, rba}, 32'hC3);

    // R12: held strobe loads only once
    @(negedge clk); a_in = 8'h11;
    @(negedge clk); cap_ab = 1'b1;
    repeat (6) @(negedge clk); a_in = 8'h22;
    repeat (6) @(negedge clk); cap_ab = 1'b0;
    repeat (6) @(negedge clk);
    read_stored(rab, rba);
    chk("R12 held strobe", {24'd0, rab}, 32'h11);
    capture(1'b1, 1'b0, 8'h22, 8'h00);
    read_stored(rab, rba);
    chk("R12 next edge", {24'd0, rab}, 32'h22);

    // Full control truth table with known stored and live values
    capture(1'b1, 1'b1, 8'h5B, 8'hE4);
    @(negedge clk); a_in = 8'h81; b_in = 8'h18;
    for (int k = 0; k < 16; k++) begin
      logic en_n, dir, sab, sba, da, db;
      logic [W-1:0] ea, eb;
      en_n = k[3]; dir = k[2]; sab = k[1]; sba = k[0];
      da = !en_n && !dir;
      db = !en_n && dir;
      ea = da ? (sba ? 8'hE4 : 8'h18) : 8'h00;
      eb = db ? (sab ? 8'h5B : 8'h81) : 8'h00;
      ctrl(en_n, dir, sab, sba);
      chk(en_n ? "R4 a_drv" : "R5 a_drv", {24'd0, a_drv}, {24'd0, {W{da}}});
      chk(en_n ? "R4 b_drv" : "R5 b_drv", {24'd0, b_drv}, {24'd0, {W{db}}});
      chk("R6 a_out", {24'd0, a_out}, {24'd0, ea});
      chk("R7 b_out", {24'd0, b_out}, {24'd0, eb});
      chk("R8 exclusive", {31'd0, (|a_drv) && (|b_drv)}, 32'd0);
    end

    // R9: all byte values through the live paths, both directions
    for (int v = 0; v < 256; v++) begin
      ctrl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = v[7:0]; #1;
      chk("R9 a to b", {24'd0, b_out}, v);
      toward_b = 1'b0; b_in = ~v[7:0]; #1;
      chk("R9 b to a", {24'd0, a_out}, {24'd0, ~v[7:0]});
    end
    // R9: walking one through both stored paths
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] wv;
      wv = 8'h01 << i;
      capture(1'b1, 1'b1, wv, ~wv);
      read_stored(rab, rba);
      chk("R9 stored ab bit", {24'd0, rab}, {24'd0, wv});
      chk("R9 stored ba bit", {24'd0, rba}, {24'd0, ~wv});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule